// File: doc/BRIEF.md
# Power Domain Transition Sequencer

This block steps up to eight power domains through their transitions under software control. Software writes a command word, one bit per domain, to start a transition. Each started domain shows a busy bit until its sequence ends. A domain that is off and marked for power-up does not finish on its own. It closes its external power switch through a request/acknowledge pair. It then raises an external-power-pending flag and holds until software sets a power-good bit in that domain's control word. Only after that does it signal the module state change and mark itself on.

A domain that is already on skips the switch handshake and moves straight to the module-change step. If its target is off, it powers down after that step. Every domain runs its own sequencer, so several transitions may overlap. A command bit aimed at a domain that is still in transition is dropped.

Register map (byte addresses, 32-bit words): command at 0x000, write-only, reads 0. Busy vector at 0x004. Pending vector at 0x008. Per-domain control words at 0x100 + 4·n: bit 0 is the power-up target, bit 1 is power-good. Per-domain status words at 0x200 + 4·n: bits [1:0] hold the power state, 0 for off and 1 for on.

Top module: `pdom_seq`

## Requirements
- R1: After reset the busy and pending vectors are 0 and every control word is 0. Each status word reads 1 for domains set in ON_AT_RESET (default: domain 0 only) and 0 otherwise. sw_req equals the on-state of each domain and mod_apply is 0.
- R2: Writing 0x000 with bit n set starts domain n if it is idle. Bit n of the busy vector (0x004) reads 1 from the next cycle until the sequence ends. Zero bits start nothing.
- R3: An off domain whose control bit 0 is 1 raises sw_req[n] in the cycle after the command. It stays busy, with its pending bit at 0, until sw_ack[n] is sampled high.
- R4: In the cycle after sw_ack[n] is sampled, pending bit n (0x008) reads 1. It holds there while control bit 1 (power-good) is 0.
- R5: Once power-good reads 1, mod_apply[n] pulses for exactly one cycle on the next cycle, and pending bit n clears in that cycle. One cycle later busy bit n is 0, the status word reads 1, and power-good reads 0 again.
- R6: A command to a domain that is already on, with a target of on, gives mod_apply[n] in the next cycle with pending at 0. The busy bit clears one cycle later.
- R7: A command to an on domain whose target (control bit 0) is 0 pulses mod_apply[n] while sw_req[n] is still high. The next cycle the status word reads 0 and sw_req[n] is low.
- R8: A command bit for a domain that is busy, including in its mod_apply cycle, is ignored. No extra mod_apply pulse follows, and busy ends on the original schedule.
- R9: Domains sequence independently. Handshakes, power-good writes and completions of one domain do not change another domain's busy, pending or mod_apply bits.
- R10: A command to an off domain whose target is 0 pulses mod_apply[n] in the next cycle. The domain stays off and sw_req[n] stays low.
- R11: Reads of the command address, of unmapped addresses and of unaligned addresses return 0. Writes to the busy or status addresses change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 12 | Register write byte address |
| wr_data | input | DATA_W | Register write data |
| rd_addr | input | 12 | Register read byte address |
| rd_data | output | DATA_W | Register read data (combinational) |
| sw_ack | input | NDOM | External power switch reports power present, per domain |
| sw_req | output | NDOM | Close the external power switch, per domain |
| mod_apply | output | NDOM | One-cycle pulse: apply pending module state changes |

## Verification
The case that needs care is a new command bit for a domain that lands in the same cycle as that domain's completion step. The bench provokes it by issuing a second command to the domain back to back, so that the write is sampled during its mod_apply cycle. The same write word also starts a different idle domain. The check requires that the busy domain gives no second pulse and goes idle on time, while the other domain starts normally. A second overlap pairs a power-good write for one domain with another domain still waiting on its switch.

// File: rtl/pdseq_pkg.sv
package pdseq_pkg;

    // Register map geometry
    localparam int MAP_AW = 12;

    localparam logic [3:0] PAGE_GLOBAL = 4'h0;
    localparam logic [3:0] PAGE_CTRL   = 4'h1;
    localparam logic [3:0] PAGE_STAT   = 4'h2;

    localparam logic [7:0] OFF_CMD  = 8'h00;
    localparam logic [7:0] OFF_BUSY = 8'h04;
    localparam logic [7:0] OFF_PEND = 8'h08;

    localparam int STATE_W = 2;
    localparam logic [STATE_W-1:0] PWR_OFF = 2'd0;
    localparam logic [STATE_W-1:0] PWR_ON  = 2'd1;

    // Per-domain sequencer states
    typedef enum logic [1:0] {
        PD_IDLE      = 2'd0,
        PD_WAIT_SW   = 2'd1,
        PD_WAIT_GOOD = 2'd2,
        PD_APPLY     = 2'd3
    } pd_fsm_e;

    // Address windows
    typedef enum logic [1:0] {
        WIN_NONE   = 2'd0,
        WIN_GLOBAL = 2'd1,
        WIN_CTRL   = 2'd2,
        WIN_STAT   = 2'd3
    } win_e;

    // Control word: bit 1 power-good, bit 0 power-up target
    typedef struct packed {
        logic pwr_good;
        logic next_on;
    } pd_ctrl_t;

    function automatic win_e page_of(input logic [MAP_AW-1:0] a);
        win_e w;
        case (a[MAP_AW-1:8])
            PAGE_GLOBAL: w = WIN_GLOBAL;
            PAGE_CTRL:   w = WIN_CTRL;
            PAGE_STAT:   w = WIN_STAT;
            default:     w = WIN_NONE;
        endcase
        return w;
    endfunction

    function automatic logic [5:0] slot_of(input logic [MAP_AW-1:0] a);
        return a[7:2];
    endfunction

    function automatic logic word_ok(input logic [MAP_AW-1:0] a);
        return (a[1:0] == 2'b00);
    endfunction

    // Next state of an idle domain when a command arrives
    function automatic pd_fsm_e launch_state(input logic is_on, input logic want_on);
        pd_fsm_e s;
        if (!is_on && want_on) s = PD_WAIT_SW;
        else                   s = PD_APPLY;
        return s;
    endfunction

endpackage

// File: rtl/pdseq_dom.sv
module pdseq_dom
    import pdseq_pkg::*;
#(
    parameter logic ON_AT_RESET = 1'b0
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     start_i,
    input  logic     ctrl_we_i,
    input  pd_ctrl_t ctrl_wdata_i,
    input  logic     sw_ack_i,
    output pd_ctrl_t ctrl_o,
    output logic     busy_o,
    output logic     pend_o,
    output logic     on_o,
    output logic     sw_req_o,
    output logic     apply_o
);

    pd_fsm_e  fsm_q;
    pd_fsm_e  fsm_d;
    pd_ctrl_t ctrl_q;
    logic     on_q;
    logic     tgt_q;

    // Sequencer next-state
    always_comb begin
        fsm_d = fsm_q;
        unique case (fsm_q)
            PD_IDLE:      if (start_i)        fsm_d = launch_state(on_q, ctrl_q.next_on);
            PD_WAIT_SW:   if (sw_ack_i)       fsm_d = PD_WAIT_GOOD;
            PD_WAIT_GOOD: if (ctrl_q.pwr_good) fsm_d = PD_APPLY;
            PD_APPLY:                          fsm_d = PD_IDLE;
            default:                           fsm_d = PD_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            fsm_q  <= PD_IDLE;
            ctrl_q <= '0;
            on_q   <= ON_AT_RESET;
            tgt_q  <= ON_AT_RESET;
        end else begin
            fsm_q <= fsm_d;
            if (fsm_q == PD_IDLE && start_i) begin
                tgt_q <= ctrl_q.next_on;
            end
            if (ctrl_we_i) begin
                ctrl_q <= ctrl_wdata_i;
            end
            if (fsm_q == PD_APPLY) begin
                on_q            <= tgt_q;
                ctrl_q.pwr_good <= 1'b0;   // completion clears power-good
            end
        end
    end

    assign ctrl_o   = ctrl_q;
    assign busy_o   = (fsm_q != PD_IDLE);
    assign pend_o   = (fsm_q == PD_WAIT_GOOD);
    assign apply_o  = (fsm_q == PD_APPLY);
    assign on_o     = on_q;
    // Switch stays closed while powered and through any power-up sequence
    assign sw_req_o = on_q || (busy_o && tgt_q);

    AST_START_BUSY: assert property (@(posedge clk) disable iff (rst)
        (start_i && !busy_o) |=> busy_o);                                  // R2
    AST_PEND_AFTER_ACK: assert property (@(posedge clk) disable iff (rst)
        $rose(pend_o) |-> $past(sw_ack_i));                                // R4
    AST_PEND_HOLD: assert property (@(posedge clk) disable iff (rst)
        (pend_o && !ctrl_o.pwr_good) |=> pend_o);                          // R4
    AST_APPLY_PULSE: assert property (@(posedge clk) disable iff (rst)
        apply_o |=> !apply_o);                                             // R5
    AST_GOOD_CLEARED: assert property (@(posedge clk) disable iff (rst)
        apply_o |=> !ctrl_o.pwr_good);                                     // R5
    AST_NO_RESTART: assert property (@(posedge clk) disable iff (rst)
        apply_o |=> !busy_o);                                              // R8
    AST_POWER_DOWN: assert property (@(posedge clk) disable iff (rst)
        (apply_o && !sw_req_o) |=> !on_o);                                 // R10

endmodule

// File: rtl/pdseq_regif.sv
module pdseq_regif
    import pdseq_pkg::*;
#(
    parameter int NDOM   = 8,
    parameter int DATA_W = 32
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  wr_en,
    input  logic [MAP_AW-1:0]     wr_addr,
    input  logic [DATA_W-1:0]     wr_data,
    input  logic [MAP_AW-1:0]     rd_addr,
    input  pd_ctrl_t [NDOM-1:0]   ctrl_i,
    input  logic [NDOM-1:0]       busy_i,
    input  logic [NDOM-1:0]       pend_i,
    input  logic [NDOM-1:0]       on_i,
    output logic [NDOM-1:0]       cmd_start_o,
    output logic [NDOM-1:0]       ctrl_we_o,
    output pd_ctrl_t              ctrl_wdata_o,
    output logic [DATA_W-1:0]     rd_data
);

    localparam int CTRL_W = $bits(pd_ctrl_t);

    logic unused_wr_bits;
    assign unused_wr_bits = ^wr_data[DATA_W-1:NDOM];

    logic wr_global;
    logic wr_ctrl;
    assign wr_global = wr_en && word_ok(wr_addr) && (page_of(wr_addr) == WIN_GLOBAL);
    assign wr_ctrl   = wr_en && word_ok(wr_addr) && (page_of(wr_addr) == WIN_CTRL);

    assign cmd_start_o  = (wr_global && wr_addr[7:0] == OFF_CMD) ? wr_data[NDOM-1:0] : '0;
    assign ctrl_wdata_o = pd_ctrl_t'(wr_data[CTRL_W-1:0]);

    always_comb begin
        ctrl_we_o = '0;
        for (int n = 0; n < NDOM; n++) begin
            if (wr_ctrl && int'(slot_of(wr_addr)) == n) ctrl_we_o[n] = 1'b1;
        end
    end

    // Read mux
    always_comb begin
        rd_data = '0;
        if (word_ok(rd_addr)) begin
            case (page_of(rd_addr))
                WIN_GLOBAL: begin
                    case (rd_addr[7:0])
                        OFF_BUSY: rd_data[NDOM-1:0] = busy_i;
                        OFF_PEND: rd_data[NDOM-1:0] = pend_i;
                        default:  rd_data = '0;
                    endcase
                end
                WIN_CTRL: begin
                    for (int n = 0; n < NDOM; n++) begin
                        if (int'(slot_of(rd_addr)) == n) rd_data[CTRL_W-1:0] = ctrl_i[n];
                    end
                end
                WIN_STAT: begin
                    for (int n = 0; n < NDOM; n++) begin
                        if (int'(slot_of(rd_addr)) == n)
                            rd_data[STATE_W-1:0] = on_i[n] ? PWR_ON : PWR_OFF;
                    end
                end
                default: rd_data = '0;
            endcase
        end
    end

    AST_CTRL_WE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        $onehot0(ctrl_we_o));                                              // R11
    AST_CMD_NEEDS_WRITE: assert property (@(posedge clk) disable iff (rst)
        (|cmd_start_o) |-> (wr_en && !wr_ctrl));                           // R2

endmodule

// File: rtl/pdom_seq.sv
module pdom_seq
    import pdseq_pkg::*;
#(
    parameter int              NDOM        = 8,
    parameter int              DATA_W      = 32,
    parameter logic [NDOM-1:0] ON_AT_RESET = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [11:0]       wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [11:0]       rd_addr,
    output logic [DATA_W-1:0] rd_data,
    input  logic [NDOM-1:0]   sw_ack,
    output logic [NDOM-1:0]   sw_req,
    output logic [NDOM-1:0]   mod_apply
);

    pd_ctrl_t [NDOM-1:0] ctrl_v;
    pd_ctrl_t            ctrl_wdata;
    logic [NDOM-1:0]     cmd_start;
    logic [NDOM-1:0]     ctrl_we;
    logic [NDOM-1:0]     busy_v;
    logic [NDOM-1:0]     pend_v;
    logic [NDOM-1:0]     on_v;

    pdseq_regif #(
        .NDOM   (NDOM),
        .DATA_W (DATA_W)
    ) u_regif (
        .clk          (clk),
        .rst          (rst),
        .wr_en        (wr_en),
        .wr_addr      (wr_addr),
        .wr_data      (wr_data),
        .rd_addr      (rd_addr),
        .ctrl_i       (ctrl_v),
        .busy_i       (busy_v),
        .pend_i       (pend_v),
        .on_i         (on_v),
        .cmd_start_o  (cmd_start),
        .ctrl_we_o    (ctrl_we),
        .ctrl_wdata_o (ctrl_wdata),
        .rd_data      (rd_data)
    );

    for (genvar g = 0; g < NDOM; g++) begin : g_dom
        pdseq_dom #(
            .ON_AT_RESET (ON_AT_RESET[g])
        ) u_dom (
            .clk          (clk),
            .rst          (rst),
            .start_i      (cmd_start[g]),
            .ctrl_we_i    (ctrl_we[g]),
            .ctrl_wdata_i (ctrl_wdata),
            .sw_ack_i     (sw_ack[g]),
            .ctrl_o       (ctrl_v[g]),
            .busy_o       (busy_v[g]),
            .pend_o       (pend_v[g]),
            .on_o         (on_v[g]),
            .sw_req_o     (sw_req[g]),
            .apply_o      (mod_apply[g])
        );
    end

    AST_PEND_IMPLIES_REQ: assert property (@(posedge clk) disable iff (rst)
        ((pend_v & ~sw_req) == '0));                                       // R3
    AST_IDLE_NO_PEND: assert property (@(posedge clk) disable iff (rst)
        $fell(busy_v[0]) |-> !pend_v[0]);                                  // R9

endmodule

// File: tb/tb_pdom_seq.sv
`timescale 1ns/10ps
module tb_pdom_seq;

    localparam int NDOM = 8;
    localparam int DW   = 32;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            wr_en = 1'b0;
    logic [11:0]     wr_addr = '0;
    logic [DW-1:0]   wr_data = '0;
    logic [11:0]     rd_addr = '0;
    logic [DW-1:0]   rd_data;
    logic [NDOM-1:0] sw_ack = '0;
    logic [NDOM-1:0] sw_req;
    logic [NDOM-1:0] mod_apply;

    int n_chk  = 0;
    int n_fail = 0;
    int apply_cnt [NDOM];

    always #5 clk = ~clk;

    pdom_seq dut (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .rd_addr   (rd_addr),
        .rd_data   (rd_data),
        .sw_ack    (sw_ack),
        .sw_req    (sw_req),
        .mod_apply (mod_apply)
    );

    always @(posedge clk) begin
        for (int d = 0; d < NDOM; d++) begin
            if (rst) apply_cnt[d] <= 0;
            else if (mod_apply[d]) apply_cnt[d] <= apply_cnt[d] + 1;
        end
    end

    // Reset-state read vectors: {address, expected}
    localparam int NVEC = 10;
    localparam logic [43:0] RST_VEC [NVEC] = '{
        {12'h000, 32'h0000_0000},
        {12'h004, 32'h0000_0000},
        {12'h008, 32'h0000_0000},
        {12'h100, 32'h0000_0000},
        {12'h11C, 32'h0000_0000},
        {12'h200, 32'h0000_0001},
        {12'h204, 32'h0000_0000},
        {12'h21C, 32'h0000_0000},
        {12'h300, 32'h0000_0000},
        {12'h201, 32'h0000_0000}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual=0x%08h expected=0x%08h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        rd_addr = a;
        #0.01;
        d = rd_data;
    endtask

    task automatic rchk(input string req, input logic [11:0] a, input logic [31:0] exp);
        logic [31:0] v;
        rd(a, v);
        chk(req, v, exp);
    endtask

    // Called at a falling edge; returns at the next falling edge
    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        step();

        // R1 / R11: reset state through the read table
        for (int i = 0; i < NVEC; i++) begin
            rchk("R1/R11 reset read", RST_VEC[i][43:32], RST_VEC[i][31:0]);
        end
        chk("R1 sw_req", 32'(sw_req), 32'h01);
        chk("R1 mod_apply", 32'(mod_apply), 32'h00);

        // R3/R4/R5: power up off domain 2
        wr(12'h108, 32'h1);
        wr(12'h000, 32'h4);
        chk("R3 sw_req rises", 32'(sw_req), 32'h05);
        rchk("R2 busy set", 12'h004, 32'h04);
        rchk("R3 no pend before ack", 12'h008, 32'h00);
        repeat (3) step();
        rchk("R3 still busy w/o ack", 12'h004, 32'h04);
        rchk("R3 still no pend", 12'h008, 32'h00);
        sw_ack[2] = 1'b1;
        step();
        rchk("R4 pend after ack", 12'h008, 32'h04);
        repeat (3) step();
        rchk("R4 pend held", 12'h008, 32'h04);
        chk("R4 no apply w/o good", 32'(mod_apply), 32'h00);
        wr(12'h108, 32'h3);
        chk("R5 no apply yet", 32'(mod_apply), 32'h00);
        step();
        chk("R5 apply pulse", 32'(mod_apply), 32'h04);
        rchk("R5 pend cleared", 12'h008, 32'h00);
        step();
        chk("R5 apply single", 32'(mod_apply), 32'h00);
        rchk("R5 busy cleared", 12'h004, 32'h00);
        rchk("R5 state on", 12'h208, 32'h01);
        rchk("R5 good cleared", 12'h108, 32'h01);

        // R6: already-on domain 0
        wr(12'h100, 32'h1);
        wr(12'h000, 32'h1);
        chk("R6 direct apply", 32'(mod_apply), 32'h01);
        rchk("R6 busy one cycle", 12'h004, 32'h01);
        rchk("R6 no pend", 12'h008, 32'h00);
        step();
        rchk("R6 busy cleared", 12'h004, 32'h00);
        rchk("R6 state on", 12'h200, 32'h01);

        // R8/R10/R9: command to domain 0 in its apply cycle, domain 3 starts alongside
        wr(12'h000, 32'h1);
        chk("R8 first apply", 32'(mod_apply), 32'h01);
        wr(12'h000, 32'h9);
        chk("R8/R10 only domain 3 applies", 32'(mod_apply), 32'h08);
        rchk("R8 domain 0 idle", 12'h004, 32'h08);
        step();
        rchk("R10 busy cleared", 12'h004, 32'h00);
        rchk("R10 stays off", 12'h20C, 32'h00);
        chk("R10 no switch req", 32'(sw_req[3]), 32'h0);
        chk("R8 apply count d0", 32'(apply_cnt[0]), 32'd2);

        // R9: domains 4 and 5 overlap, R8 ignored command while waiting
        wr(12'h110, 32'h1);
        wr(12'h114, 32'h1);
        wr(12'h000, 32'h30);
        rchk("R9 both busy", 12'h004, 32'h30);
        chk("R9 both req", 32'(sw_req & 8'h30), 32'h30);
        sw_ack[5] = 1'b1;
        step();
        rchk("R9 only 5 pending", 12'h008, 32'h20);
        wr(12'h000, 32'h10);
        wr(12'h114, 32'h3);
        step();
        chk("R9 only 5 applies", 32'(mod_apply), 32'h20);
        rchk("R9 4 still busy", 12'h004, 32'h30);
        step();
        rchk("R9 5 done, 4 busy", 12'h004, 32'h10);
        rchk("R9 5 on", 12'h214, 32'h01);
        rchk("R9 4 off", 12'h210, 32'h00);
        sw_ack[4] = 1'b1;
        step();
        rchk("R9 4 pending", 12'h008, 32'h10);
        wr(12'h110, 32'h3);
        step();
        chk("R9 4 applies", 32'(mod_apply), 32'h10);
        step();
        rchk("R9 all idle", 12'h004, 32'h00);
        chk("R8 apply count d4", 32'(apply_cnt[4]), 32'd1);

        // R7: power down domain 2
        wr(12'h108, 32'h0);
        wr(12'h000, 32'h4);
        chk("R7 apply", 32'(mod_apply), 32'h04);
        chk("R7 req held in apply", 32'(sw_req[2]), 32'h1);
        step();
        rchk("R7 state off", 12'h208, 32'h00);
        chk("R7 req dropped", 32'(sw_req[2]), 32'h0);
        sw_ack[2] = 1'b0;

        // R2 / R11: no-op writes
        wr(12'h000, 32'h0);
        rchk("R2 zero command", 12'h004, 32'h00);
        chk("R2 no apply", 32'(mod_apply), 32'h00);
        wr(12'h004, 32'hFF);
        rchk("R11 busy write ignored", 12'h004, 32'h00);
        wr(12'h200, 32'h0);
        rchk("R11 status write ignored", 12'h200, 32'h01);
        rchk("R11 cmd reads zero", 12'h000, 32'h00);
        chk("R11 no apply", 32'(mod_apply), 32'h00);

        summary();
        $finish;
    end

endmodule